// File: doc/BRIEF.md
# Dual-window bitstream density detector

This block sits after an isolation barrier and a clock-domain synchronizer. It takes a one-bit sigma-delta stream, where each received bit is qualified by a valid strobe, and turns it into two density estimates. A short window gives a quick "suspect" estimate and a long window gives a confirming estimate. The two windows run side by side on the same stream. Each window counts the ones it received. When a window closes, it compares that count with its own entry and exit thresholds and checks whether the count is pinned near empty or near full scale.

Each window can close in one of two ways. In bit mode it closes after a programmed number of received bits. In time mode it closes after a programmed number of system clocks. Time mode keeps the window length fixed in real time even when pulses are swallowed on the link. In that mode the number of bits actually received is reported, so that a later stage can judge the health of the link. Window lengths, the mode and the thresholds are taken only at a window boundary. Windows follow each other without gaps, so every accepted bit lands in exactly one window.

Top module: `density_window_pair`

## Requirements
- R1: A window's reported count equals the number of bits accepted with `bitValid` high and `bitIn` high during that window. Bits offered while `bitValid` is low are never counted, and the count never exceeds the reported bit total.
- R2: In bit mode (`timeMode`=0 when the window opened), a window closes on the clock edge that accepts its N-th valid bit. N is its `winLen` entry, and a length of 0 acts as 1. It then reports `winBits` = N.
- R3: `winDone` pulses high for the one cycle after the closing edge, together with the new results. The next accepted bit goes into the following window, so windows follow each other with no lost or doubly counted bit.
- R4: At close, `winAbove` is 1 exactly when count > entry threshold, and `winBelow` is 1 exactly when count < exit threshold. Both use the thresholds in force for that window.
- R5: At close, `winOvld` is 1 when count ≤ OVLD_MARGIN (default 1) or count + OVLD_MARGIN ≥ bits received.
- R6: Mode, length, tick count and thresholds are sampled only when a window opens. A change in the middle of a window first applies to the next window.
- R7: In time mode (`timeMode`=1 when the window opened), a window closes after T clocks, whatever the number of bits received. T is its `winTicks` entry, and 0 acts as 1. `winBits` reports how many valid bits it took in.
- R8: Index 0 (fast) and index 1 (slow) run independently on the same stream. Both may close on the same edge, and both then count the bit accepted on that edge.
- R9: In reset, all outputs are 0. The first cycle after reset release loads the configuration and ignores the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Qualifies `bitIn` in this cycle |
| bitIn | input | 1 | Synchronized modulator bit |
| timeMode | input | 1 | 1 = time windows, 0 = bit-count windows |
| winLen | input | 2×W | Bit length per window (index 0 fast, 1 slow) |
| winTicks | input | 2×W | Clock length per window in time mode |
| enterTh | input | 2×W | Entry threshold per window |
| exitTh | input | 2×W | Exit threshold per window |
| winCount | output | 2×W | Ones counted in the last closed window |
| winBits | output | 2×W | Valid bits received in the last closed window |
| winAbove | output | 2 | Count above entry threshold |
| winBelow | output | 2 | Count below exit threshold |
| winOvld | output | 2 | Count pinned near zero or full scale |
| winDone | output | 2 | One-cycle window-closed strobe |

## Verification
The case of interest is the fast and the slow window closing on the same clock edge. The bench sets the slow length to a multiple of the fast length and feeds valid bits in every cycle, so the two boundaries meet. It then checks that the bit taken on that edge is counted in both closing windows and in neither following window. A second coincidence joins a configuration write with a boundary: the bench rewrites lengths and thresholds every few cycles, in both modes. It judges each closed window against the settings a reference model captured when that window opened. The number of same-edge closes is also counted and must be nonzero.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  // Strobes from a window controller to its datapath.
  typedef struct packed {
    logic load;   // take a fresh configuration for the window now opening
    logic take;   // a valid stream bit is accepted this cycle
    logic close;  // the current window ends on this edge
  } winStrobe_t;
endpackage

// File: rtl/dwd_window_ctrl.sv
module dwd_window_ctrl
  import dwd_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitValid,
  input  logic         timeMode,
  input  logic [W-1:0] lenIn,
  input  logic [W-1:0] ticksIn,
  output winStrobe_t   strobe
);
  logic         armed;
  logic         modeQ;
  logic [W-1:0] lenQ;
  logic [W-1:0] ticksQ;
  logic [W-1:0] posCnt;
  logic [W-1:0] limit;
  logic [W-1:0] effLimit;
  logic         winEvent;
  logic         endReached;

  always_comb begin
    limit      = modeQ ? ticksQ : lenQ;
    effLimit   = (limit == '0) ? W'(1) : limit;
    winEvent   = armed && (modeQ || bitValid);
    endReached = winEvent && (({1'b0, posCnt} + 1'b1) >= {1'b0, effLimit});
    strobe.take  = armed && bitValid;
    strobe.close = endReached;
    strobe.load  = !armed || endReached;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      modeQ  <= 1'b0;
      lenQ   <= '0;
      ticksQ <= '0;
      posCnt <= '0;
    end else begin
      armed <= 1'b1;
      if (strobe.load) begin
        modeQ  <= timeMode;
        lenQ   <= lenIn;
        ticksQ <= ticksIn;
        posCnt <= '0;
      end else if (winEvent) begin
        posCnt <= posCnt + 1'b1;
      end
    end
  end

  // Position inside an open window always stays short of its effective length.
  assert_pos_below_limit_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (posCnt < effLimit));

endmodule

// File: rtl/dwd_window_dp.sv
module dwd_window_dp
  import dwd_pkg::*;
#(
  parameter int W           = 10,
  parameter int OVLD_MARGIN = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitIn,
  input  winStrobe_t   strobe,
  input  logic [W-1:0] enterIn,
  input  logic [W-1:0] exitIn,
  output logic [W-1:0] resCount,
  output logic [W-1:0] resBits,
  output logic         resAbove,
  output logic         resBelow,
  output logic         resOvld,
  output logic         resDone
);
  localparam logic [W:0] MARGIN = (W+1)'(OVLD_MARGIN);

  logic [W-1:0] onesCnt;
  logic [W-1:0] bitsCnt;
  logic [W-1:0] enterQ;
  logic [W-1:0] exitQ;
  logic [W-1:0] finalOnes;
  logic [W-1:0] finalBits;
  logic         ovldNow;

  always_comb begin
    finalOnes = onesCnt + W'(strobe.take & bitIn);
    finalBits = bitsCnt + W'(strobe.take);
    ovldNow   = ({1'b0, finalOnes} <= MARGIN) ||
                (({1'b0, finalOnes} + MARGIN) >= {1'b0, finalBits});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesCnt  <= '0;
      bitsCnt  <= '0;
      enterQ   <= '0;
      exitQ    <= '0;
      resCount <= '0;
      resBits  <= '0;
      resAbove <= 1'b0;
      resBelow <= 1'b0;
      resOvld  <= 1'b0;
      resDone  <= 1'b0;
    end else begin
      if (strobe.load) begin
        enterQ <= enterIn;
        exitQ  <= exitIn;
      end
      if (strobe.close) begin
        resCount <= finalOnes;
        resBits  <= finalBits;
        resAbove <= finalOnes > enterQ;
        resBelow <= finalOnes < exitQ;
        resOvld  <= ovldNow;
        resDone  <= 1'b1;
        onesCnt  <= '0;
        bitsCnt  <= '0;
      end else begin
        resDone <= 1'b0;
        onesCnt <= finalOnes;
        bitsCnt <= finalBits;
      end
    end
  end

  assert_running_ones_le_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= bitsCnt);

  assert_count_le_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> (resCount <= resBits));

  assert_ovld_at_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resDone && resCount == '0) |-> resOvld);

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.close && enterQ >= exitQ) |=> !(resAbove && resBelow));

  assert_first_load_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.close) |-> (onesCnt == '0 && bitsCnt == '0));

endmodule

// File: rtl/density_window_pair.sv
module density_window_pair
  import dwd_pkg::*;
#(
  parameter int W           = 10,
  parameter int OVLD_MARGIN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              timeMode,
  input  logic [1:0][W-1:0] winLen,
  input  logic [1:0][W-1:0] winTicks,
  input  logic [1:0][W-1:0] enterTh,
  input  logic [1:0][W-1:0] exitTh,
  output logic [1:0][W-1:0] winCount,
  output logic [1:0][W-1:0] winBits,
  output logic [1:0]        winAbove,
  output logic [1:0]        winBelow,
  output logic [1:0]        winOvld,
  output logic [1:0]        winDone
);
  localparam int NWIN = 2;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    winStrobe_t strobe;

    dwd_window_ctrl #(.W(W)) i_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .bitValid (bitValid),
      .timeMode (timeMode),
      .lenIn    (winLen[w]),
      .ticksIn  (winTicks[w]),
      .strobe   (strobe)
    );

    dwd_window_dp #(.W(W), .OVLD_MARGIN(OVLD_MARGIN)) i_dp (
      .clk      (clk),
      .rstN     (rstN),
      .bitIn    (bitIn),
      .strobe   (strobe),
      .enterIn  (enterTh[w]),
      .exitIn   (exitTh[w]),
      .resCount (winCount[w]),
      .resBits  (winBits[w]),
      .resAbove (winAbove[w]),
      .resBelow (winBelow[w]),
      .resOvld  (winOvld[w]),
      .resDone  (winDone[w])
    );
  end

endmodule

// File: tb/test_density_window_pair.sv
`timescale 1ns/1ps
module test_density_window_pair;
  localparam int W = 10;
  localparam int M = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic timeMode = 1'b0;
  logic [1:0][W-1:0] winLen = '0;
  logic [1:0][W-1:0] winTicks = '0;
  logic [1:0][W-1:0] enterTh = '0;
  logic [1:0][W-1:0] exitTh = '0;
  logic [1:0][W-1:0] winCount;
  logic [1:0][W-1:0] winBits;
  logic [1:0] winAbove, winBelow, winOvld, winDone;

  density_window_pair #(.W(W), .OVLD_MARGIN(M)) i_density_window_pair (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn), .timeMode(timeMode),
    .winLen(winLen), .winTicks(winTicks), .enterTh(enterTh), .exitTh(exitTh),
    .winCount(winCount), .winBits(winBits), .winAbove(winAbove), .winBelow(winBelow),
    .winOvld(winOvld), .winDone(winDone)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int coincide = 0;
  string doneTag = "R3";
  logic [15:0] lfsr = 16'hACE1;

  // configuration presented at the ports
  int cfgLen[2], cfgTicks[2], cfgEnter[2], cfgExit[2];
  bit cfgMode;

  // reference model state
  bit mArmed[2], mMode[2];
  int mLen[2], mTicks[2], mEnter[2], mExit[2], mOnes[2], mBits[2], mPos[2];
  bit expDone[2], expAbove[2], expBelow[2], expOvld[2], expMode[2];
  int expCnt[2], expBits[2];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic modelLoad(int w);
    mMode[w] = cfgMode; mLen[w] = cfgLen[w]; mTicks[w] = cfgTicks[w];
    mEnter[w] = cfgEnter[w]; mExit[w] = cfgExit[w];
    mOnes[w] = 0; mBits[w] = 0; mPos[w] = 0;
  endtask

  task automatic step(bit v, bit b);
    bitValid = v; bitIn = b; timeMode = cfgMode;
    for (int w = 0; w < 2; w++) begin
      winLen[w] = W'(cfgLen[w]); winTicks[w] = W'(cfgTicks[w]);
      enterTh[w] = W'(cfgEnter[w]); exitTh[w] = W'(cfgExit[w]);
    end
    for (int w = 0; w < 2; w++) begin
      expDone[w] = 1'b0;
      if (!mArmed[w]) begin
        mArmed[w] = 1'b1;
        modelLoad(w);
      end else begin
        int lim;
        bit ev;
        if (v) begin mBits[w]++; if (b) mOnes[w]++; end
        ev = mMode[w] ? 1'b1 : v;
        if (ev) mPos[w]++;
        lim = mMode[w] ? mTicks[w] : mLen[w];
        if (lim == 0) lim = 1;
        if (ev && mPos[w] >= lim) begin
          expDone[w]  = 1'b1;
          expMode[w]  = mMode[w];
          expCnt[w]   = mOnes[w];
          expBits[w]  = mBits[w];
          expAbove[w] = mOnes[w] > mEnter[w];
          expBelow[w] = mOnes[w] < mExit[w];
          expOvld[w]  = (mOnes[w] <= M) || (mOnes[w] + M >= mBits[w]);
          modelLoad(w);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int w = 0; w < 2; w++) begin
      check(winDone[w] == expDone[w], doneTag, $sformatf("win%0d done", w), int'(winDone[w]), int'(expDone[w]));
      if (expDone[w]) begin
        check(int'(winCount[w]) == expCnt[w], "R1", $sformatf("win%0d count", w), int'(winCount[w]), expCnt[w]);
        check(int'(winBits[w]) == expBits[w], expMode[w] ? "R7" : "R2", $sformatf("win%0d bits", w), int'(winBits[w]), expBits[w]);
        check(winAbove[w] == expAbove[w], "R4", $sformatf("win%0d above", w), int'(winAbove[w]), int'(expAbove[w]));
        check(winBelow[w] == expBelow[w], "R4", $sformatf("win%0d below", w), int'(winBelow[w]), int'(expBelow[w]));
        check(winOvld[w] == expOvld[w], "R5", $sformatf("win%0d ovld", w), int'(winOvld[w]), int'(expOvld[w]));
      end
    end
    if (expDone[0] && expDone[1]) coincide++;
  endtask

  task automatic setCfg(bit mode, int fl, int sl, int ft, int st, int fe, int fx, int se, int sx);
    cfgMode = mode; cfgLen[0] = fl; cfgLen[1] = sl; cfgTicks[0] = ft; cfgTicks[1] = st;
    cfgEnter[0] = fe; cfgExit[0] = fx; cfgEnter[1] = se; cfgExit[1] = sx;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    setCfg(1'b0, 2, 8, 4, 16, 1, 1, 5, 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: outputs held at zero in reset
    check(winDone == 2'b00, "R9", "reset done", int'(winDone), 0);
    check(winCount == '0 && winBits == '0, "R9", "reset counts", int'(winCount[0]), 0);
    check(winAbove == 2'b00 && winBelow == 2'b00 && winOvld == 2'b00, "R9", "reset flags", int'(winOvld), 0);
    rstN = 1'b1;

    // R9: the load cycle ignores a valid one; the next two zeros fill the fast window
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check(winDone[0] == 1'b1 && winCount[0] == '0, "R9", "first window ignores load-cycle bit", int'(winCount[0]), 0);

    // Phase A: bit mode, random valid and data
    doneTag = "R3";
    setCfg(1'b0, 5, 20, 4, 16, 3, 2, 12, 8);
    for (int i = 0; i < 400; i++) begin nextRand(); step(lfsr[0] | lfsr[3], lfsr[5]); end

    // Phase B: density sweep 0..4 quarters, valid every cycle, then valid low with ones offered (R1)
    for (int d = 0; d <= 4; d++)
      for (int i = 0; i < 60; i++) step(1'b1, (i % 4) < d);
    for (int i = 0; i < 30; i++) step(i % 3 == 0, 1'b1);

    // Phase C: degenerate lengths 0 and 1 (R2)
    doneTag = "R2";
    setCfg(1'b0, 0, 1, 4, 16, 0, 1, 0, 1);
    for (int i = 0; i < 30; i++) begin nextRand(); step(lfsr[2], lfsr[7]); end

    // Phase D: time mode with swallowed bits (R7), including tick count 0
    doneTag = "R7";
    setCfg(1'b1, 5, 20, 7, 25, 3, 2, 10, 4);
    for (int i = 0; i < 300; i++) begin nextRand(); step(lfsr[1] & (lfsr[4] | lfsr[9]), lfsr[6]); end
    cfgTicks[0] = 0;
    for (int i = 0; i < 40; i++) begin nextRand(); step(lfsr[3], lfsr[8]); end

    // Phase E: configuration rewritten mid-window (R6)
    doneTag = "R6";
    for (int i = 0; i < 400; i++) begin
      nextRand();
      if (i % 3 == 0) begin
        cfgLen[0] = 3 + (i % 5); cfgEnter[0] = i % 4; cfgExit[0] = (i / 3) % 3;
        cfgTicks[1] = 9 + (i % 7); cfgLen[1] = 10 + (i % 9);
        cfgEnter[1] = (i / 2) % 8; cfgExit[1] = i % 6;
      end
      if (i % 11 == 0) cfgMode = ~cfgMode;
      step(lfsr[0] | lfsr[11], lfsr[13]);
    end

    // Phase F: slow length a multiple of fast, every cycle valid (R8)
    doneTag = "R8";
    setCfg(1'b0, 4, 12, 4, 12, 2, 1, 7, 4);
    for (int i = 0; i < 120; i++) begin nextRand(); step(1'b1, lfsr[4]); end
    check(coincide > 0, "R8", "same-edge closes seen", coincide, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule